// File: doc/BRIEF.md
# Deterministic Quantum Phase Controller

This block sequences a group of GPU wavefronts through a repeating three-phase cycle that makes parallel execution reproducible. In the parallel phase every live wavefront runs freely until it hits a quantum boundary. A boundary is one of four things: it retires a programmed number of instructions, it issues an atomic operation or a memory fence, it arrives at a workgroup barrier, or it finishes. Once every wavefront that has not finished is parked at a boundary, the controller enters a commit phase and waits for the store-buffer flush to be acknowledged.

After the commit, the controller enters a serial phase if any parked wavefront stopped for a reason other than a barrier. In the serial phase, compute units take turns in ascending index order. On each turn, only the wavefronts of that unit that are holding an atomic or fence are allowed to run, and the turn ends when the serial operation is acknowledged. If every parked wavefront is waiting at a barrier, the serial phase is skipped. In either case the next parallel phase then starts with fresh instruction counts.

When every wavefront has finished, the controller parks in an idle state and flags kernel completion. The memory datapath and the store buffers lie outside this block. The block only sees their completion pulses.

Top module: `quantum_phase_ctrl`

## Requirements
- R1: After reset the phase is parallel (mode code 0), every run enable is high, the serial turn index is 0 and kernel_done is low.
- R2: In the parallel phase a running wavefront whose count of retire pulses since the phase began reaches or exceeds quantum_size has its run enable dropped on the next cycle.
- R3: An atomic or fence pulse on a running wavefront drops its run enable on the next cycle and marks it as holding a serial operation.
- R4: A barrier pulse on a running wavefront drops its run enable on the next cycle and marks it as waiting at a barrier.
- R5: A done pulse on a running wavefront retires it for good: its run enable stays low in every later phase, and it no longer counts in the all-at-boundary test.
- R6: When every unfinished wavefront is stopped and at least one exists, the mode becomes commit (code 1) on the next cycle, and all run enables are low during commit.
- R7: A commit_ack pulse during commit moves to serial mode (code 2) with turn index 0 if any stopped wavefront did not stop at a barrier; otherwise it returns directly to parallel mode.
- R8: In serial mode the turn index steps 0,1,…,NUM_CU-1 on each serial_ack pulse. Wavefront w belongs to compute unit w/(NUM_WF/NUM_CU). Only wavefronts of the current unit that hold an atomic or fence have run enable high.
- R9: A serial_ack pulse on the last turn returns to parallel mode. Every unfinished wavefront then runs again with its instruction count restarted from zero.
- R10: Event pulses on a wavefront whose run enable is low, and acknowledge pulses outside their own phase, have no effect.
- R11: When every wavefront has finished, the mode becomes idle (code 3) with kernel_done high and all run enables low, and it stays there until reset.
- R12: Simultaneous events on one running wavefront resolve with done first, then atomic/fence, then barrier, then retire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quantum_size | input | QW (16) | Instruction budget per wavefront per parallel phase |
| ev_retire | input | NUM_WF (8) | Per-wavefront instruction-retired pulse |
| ev_atomic | input | NUM_WF (8) | Per-wavefront atomic operation reached |
| ev_fence | input | NUM_WF (8) | Per-wavefront memory fence reached |
| ev_barrier | input | NUM_WF (8) | Per-wavefront workgroup barrier reached |
| ev_done | input | NUM_WF (8) | Per-wavefront work finished |
| commit_ack | input | 1 | Store-buffer commit finished |
| serial_ack | input | 1 | Current compute unit's serial operations finished |
| run_en | output | NUM_WF (8) | Per-wavefront permission to execute |
| mode | output | 2 | 0 parallel, 1 commit, 2 serial, 3 idle |
| serial_cu | output | max(1,clog2(NUM_CU)) | Compute unit holding the serial turn |
| kernel_done | output | 1 | All wavefronts finished |

## Verification
A wrong per-wavefront stop flag or stop reason becomes visible at run_en right away. The next symptom is the phase transition: the mode moves to commit one cycle early or late, or a serial phase is wrongly skipped or entered when commit_ack arrives. A miscounted instruction counter shifts the cycle in which that wavefront's run enable falls. A counter that is not cleared on resume shows up in the first quantum after a serial or commit phase. The bench compares every output with a behavioural model on every cycle, so any of these faults is reported in the cycle it first reaches a port.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    PH_PARALLEL = 2'd0,
    PH_COMMIT   = 2'd1,
    PH_SERIAL   = 2'd2,
    PH_IDLE     = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    STOP_COUNT   = 2'd0,
    STOP_BARRIER = 2'd1,
    STOP_SYNC    = 2'd2
  } stop_why_e;

  // Compute unit that owns a wavefront slot.
  function automatic int unsigned unit_of(int unsigned wf, int unsigned per_unit);
    return wf / per_unit;
  endfunction

  // True once the retired count has used up the quantum.
  function automatic logic budget_spent(int unsigned retired, int unsigned budget);
    return retired >= budget;
  endfunction

endpackage

// File: rtl/qpc_wave_slot.sv
module qpc_wave_slot
  import qpc_pkg::*;
#(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_parallel,
  input  logic          resume,
  input  logic [QW-1:0] quantum_size,
  input  logic          ev_retire,
  input  logic          ev_atomic,
  input  logic          ev_fence,
  input  logic          ev_barrier,
  input  logic          ev_done,
  output logic          par_run,
  output logic          stopped,
  output logic          finished,
  output logic          at_barrier,
  output logic          holds_sync
);

  logic [QW-1:0] retired_q;
  stop_why_e     why_q;
  logic          hit_budget;

  assign par_run    = in_parallel && !stopped && !finished;
  assign at_barrier = stopped && (why_q == STOP_BARRIER);
  assign holds_sync = stopped && (why_q == STOP_SYNC);
  assign hit_budget = budget_spent(32'(retired_q) + 32'd1, 32'(quantum_size));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retired_q <= '0;
      why_q     <= STOP_COUNT;
      stopped   <= 1'b0;
      finished  <= 1'b0;
    end else if (resume) begin
      retired_q <= '0;
      stopped   <= 1'b0;
    end else if (par_run) begin
      if (ev_done) begin
        finished <= 1'b1;
      end else if (ev_atomic || ev_fence) begin
        stopped <= 1'b1;
        why_q   <= STOP_SYNC;
      end else if (ev_barrier) begin
        stopped <= 1'b1;
        why_q   <= STOP_BARRIER;
      end else if (ev_retire) begin
        retired_q <= retired_q + QW'(1);
        if (hit_budget) begin
          stopped <= 1'b1;
          why_q   <= STOP_COUNT;
        end
      end
    end
  end

  a_r5_finished_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> finished);

  a_r10_parked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !resume) |=> (stopped && $stable(why_q) && $stable(retired_q)));

  a_r12_done_first: assert property (@(posedge clk) disable iff (!rst_n)
    (par_run && ev_done) |=> (finished && !stopped));

  a_r9_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> (!stopped && retired_q == '0));

endmodule

// File: rtl/qpc_phase_fsm.sv
module qpc_phase_fsm
  import qpc_pkg::*;
#(
  parameter int NUM_CU = 2,
  localparam int CUW   = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           all_parked,
  input  logic           all_finished,
  input  logic           need_serial,
  input  logic           commit_ack,
  input  logic           serial_ack,
  output phase_e         phase,
  output logic [CUW-1:0] turn,
  output logic           resume
);

  localparam logic [CUW-1:0] LAST_TURN = CUW'(NUM_CU - 1);

  logic skip_serial;
  logic last_turn_done;

  assign skip_serial    = (phase == PH_COMMIT) && commit_ack && !need_serial;
  assign last_turn_done = (phase == PH_SERIAL) && serial_ack && (turn == LAST_TURN);
  assign resume         = skip_serial || last_turn_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_PARALLEL;
      turn  <= '0;
    end else begin
      unique case (phase)
        PH_PARALLEL: if (all_parked) phase <= all_finished ? PH_IDLE : PH_COMMIT;
        PH_COMMIT: if (commit_ack) begin
          phase <= need_serial ? PH_SERIAL : PH_PARALLEL;
          turn  <= '0;
        end
        PH_SERIAL: if (serial_ack) begin
          if (turn == LAST_TURN) begin
            phase <= PH_PARALLEL;
            turn  <= '0;
          end else begin
            turn <= turn + CUW'(1);
          end
        end
        PH_IDLE: phase <= PH_IDLE;
        default: phase <= PH_PARALLEL;
      endcase
    end
  end

  a_r6_enter_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PARALLEL && all_parked && !all_finished) |=> (phase == PH_COMMIT));

  a_r10_commit_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COMMIT && !commit_ack) |=> (phase == PH_COMMIT));

  a_r7_skip_serial: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COMMIT && commit_ack && !need_serial) |=> (phase == PH_PARALLEL));

  a_r8_turn_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SERIAL && serial_ack && turn != LAST_TURN)
      |=> (phase == PH_SERIAL && turn == $past(turn) + CUW'(1)));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |=> (phase == PH_IDLE));

endmodule

// File: rtl/quantum_phase_ctrl.sv
module quantum_phase_ctrl
  import qpc_pkg::*;
#(
  parameter int NUM_WF  = 8,
  parameter int NUM_CU  = 2,
  parameter int QW      = 16,
  localparam int CUW    = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
  localparam int WF_PER_CU = NUM_WF / NUM_CU
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QW-1:0]     quantum_size,
  input  logic [NUM_WF-1:0] ev_retire,
  input  logic [NUM_WF-1:0] ev_atomic,
  input  logic [NUM_WF-1:0] ev_fence,
  input  logic [NUM_WF-1:0] ev_barrier,
  input  logic [NUM_WF-1:0] ev_done,
  input  logic              commit_ack,
  input  logic              serial_ack,
  output logic [NUM_WF-1:0] run_en,
  output logic [1:0]        mode,
  output logic [CUW-1:0]    serial_cu,
  output logic              kernel_done
);

  phase_e            phase;
  logic              resume;
  logic [NUM_WF-1:0] par_run;
  logic [NUM_WF-1:0] stopped;
  logic [NUM_WF-1:0] finished;
  logic [NUM_WF-1:0] at_barrier;
  logic [NUM_WF-1:0] holds_sync;
  logic [NUM_WF-1:0] serial_run;
  logic              all_parked;
  logic              all_finished;
  logic              need_serial;

  // Named events consumed by the phase sequencer.
  assign all_parked   = &(stopped | finished);
  assign all_finished = &finished;
  assign need_serial  = |(stopped & ~at_barrier);

  for (genvar w = 0; w < NUM_WF; w++) begin : g_slot
    localparam int UNIT = unit_of(w, WF_PER_CU);

    qpc_wave_slot #(.QW(QW)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_parallel (phase == PH_PARALLEL),
      .resume      (resume),
      .quantum_size(quantum_size),
      .ev_retire   (ev_retire[w]),
      .ev_atomic   (ev_atomic[w]),
      .ev_fence    (ev_fence[w]),
      .ev_barrier  (ev_barrier[w]),
      .ev_done     (ev_done[w]),
      .par_run     (par_run[w]),
      .stopped     (stopped[w]),
      .finished    (finished[w]),
      .at_barrier  (at_barrier[w]),
      .holds_sync  (holds_sync[w])
    );

    assign serial_run[w] = (phase == PH_SERIAL) && (serial_cu == CUW'(UNIT)) && holds_sync[w];
  end

  qpc_phase_fsm #(.NUM_CU(NUM_CU)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .all_parked  (all_parked),
    .all_finished(all_finished),
    .need_serial (need_serial),
    .commit_ack  (commit_ack),
    .serial_ack  (serial_ack),
    .phase       (phase),
    .turn        (serial_cu),
    .resume      (resume)
  );

  assign run_en      = par_run | serial_run;
  assign mode        = phase;
  assign kernel_done = (phase == PH_IDLE);

  a_r6_quiet_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COMMIT || phase == PH_IDLE) |-> (run_en == '0));

  a_r5_finished_never_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en & finished) == '0);

  a_r11_idle_all_done: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> all_finished);

endmodule

// File: tb/test_quantum_phase_ctrl.sv
`timescale 1ns/1ps
module test_quantum_phase_ctrl;

  localparam int NW  = 8;
  localparam int NC  = 2;
  localparam int QW  = 16;
  localparam int PER = NW / NC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [QW-1:0] quantum_size;
  logic [NW-1:0] ev_retire, ev_atomic, ev_fence, ev_barrier, ev_done;
  logic          commit_ack, serial_ack;
  logic [NW-1:0] run_en;
  logic [1:0]    mode;
  logic [0:0]    serial_cu;
  logic          kernel_done;

  always #2 clk = ~clk;

  quantum_phase_ctrl #(.NUM_WF(NW), .NUM_CU(NC), .QW(QW)) i_quantum_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .quantum_size(quantum_size),
    .ev_retire(ev_retire), .ev_atomic(ev_atomic), .ev_fence(ev_fence),
    .ev_barrier(ev_barrier), .ev_done(ev_done),
    .commit_ack(commit_ack), .serial_ack(serial_ack),
    .run_en(run_en), .mode(mode), .serial_cu(serial_cu), .kernel_done(kernel_done)
  );

  // Behavioural reference: 0 parallel, 1 commit, 2 serial, 3 idle.
  // Stop reason: 0 budget, 1 barrier, 2 atomic/fence.
  int m_mode, m_turn;
  int m_stop[NW], m_why[NW], m_fin[NW], m_cnt[NW];
  int vectors = 0, fails = 0;
  bit ended = 0;

  function automatic logic [NW-1:0] m_run();
    logic [NW-1:0] r;
    for (int w = 0; w < NW; w++)
      r[w] = (m_mode == 0 && m_stop[w] == 0 && m_fin[w] == 0) ||
             (m_mode == 2 && m_turn == w / PER && m_stop[w] == 1 && m_why[w] == 2);
    return r;
  endfunction

  task automatic m_reset();
    m_mode = 0; m_turn = 0;
    for (int w = 0; w < NW; w++) begin
      m_stop[w] = 0; m_why[w] = 0; m_fin[w] = 0; m_cnt[w] = 0;
    end
  endtask

  task automatic m_tick();
    bit parked = 1, allfin = 1, needser = 0, resume = 0;
    int next_mode = m_mode, next_turn = m_turn;
    for (int w = 0; w < NW; w++) begin
      if (m_stop[w] == 0 && m_fin[w] == 0) parked = 0;
      if (m_fin[w] == 0) allfin = 0;
      if (m_stop[w] == 1 && m_why[w] != 1) needser = 1;
    end
    case (m_mode)
      0: if (parked) next_mode = allfin ? 3 : 1;
      1: if (commit_ack) begin
           next_turn = 0;
           if (needser) next_mode = 2;
           else begin next_mode = 0; resume = 1; end
         end
      2: if (serial_ack) begin
           if (m_turn == NC - 1) begin next_mode = 0; next_turn = 0; resume = 1; end
           else next_turn = m_turn + 1;
         end
      default: ;
    endcase
    for (int w = 0; w < NW; w++) begin
      if (resume) begin
        m_stop[w] = 0; m_cnt[w] = 0;
      end else if (m_mode == 0 && m_stop[w] == 0 && m_fin[w] == 0) begin
        if (ev_done[w]) m_fin[w] = 1;
        else if (ev_atomic[w] || ev_fence[w]) begin m_stop[w] = 1; m_why[w] = 2; end
        else if (ev_barrier[w]) begin m_stop[w] = 1; m_why[w] = 1; end
        else if (ev_retire[w]) begin
          m_cnt[w]++;
          if (m_cnt[w] >= int'(quantum_size)) begin m_stop[w] = 1; m_why[w] = 0; end
        end
      end
    end
    m_mode = next_mode; m_turn = next_turn;
  endtask

  task automatic compare(input string tag);
    logic [NW-1:0] er = m_run();
    vectors++;
    if (run_en !== er || mode !== 2'(m_mode) || serial_cu !== 1'(m_turn) ||
        kernel_done !== (m_mode == 3)) begin
      fails++;
      $display("FAIL %s: run_en=%b mode=%0d turn=%0d kdone=%b, expected run_en=%b mode=%0d turn=%0d kdone=%0d",
               tag, run_en, mode, serial_cu, kernel_done, er, m_mode, m_turn, m_mode == 3);
    end
  endtask

  task automatic clear_in();
    ev_retire = '0; ev_atomic = '0; ev_fence = '0; ev_barrier = '0; ev_done = '0;
    commit_ack = 1'b0; serial_ack = 1'b0;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    m_tick();
    @(negedge clk);
    compare(tag);
    clear_in();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: run still active, expected to have ended");
    finish_run();
  end

  initial begin
    clear_in();
    quantum_size = 16'd4;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");

    // Scenario A: mixed stop reasons, serial phase over both units.
    ev_retire[0] = 1'b1; ev_atomic[1] = 1'b1; ev_fence[2] = 1'b1; ev_barrier[3] = 1'b1;
    ev_done[4] = 1'b1; ev_barrier[7:5] = 3'b111;
    step("R3 atomic/fence/barrier/done stop");
    ev_retire[0] = 1'b1; step("R2 retire 2");
    ev_retire[0] = 1'b1; step("R2 retire 3");
    ev_retire[0] = 1'b1; ev_retire[4] = 1'b1; step("R2 retire 4 hits budget");
    step("R6 commit entered");
    serial_ack = 1'b1; step("R10 serial_ack in commit ignored");
    serial_ack = 1'b1; ev_retire = '1; step("R10 events in commit ignored");
    commit_ack = 1'b1; step("R7 commit to serial");
    commit_ack = 1'b1; step("R10 commit_ack in serial ignored");
    ev_atomic = '1; step("R8 unit 0 turn");
    serial_ack = 1'b1; step("R8 unit 1 turn");
    serial_ack = 1'b1; step("R9 back to parallel");
    ev_retire[0] = 1'b1; step("R9 fresh count");
    ev_retire[0] = 1'b1; step("R9 count 2");
    ev_retire[4] = 1'b1; step("R5 finished stays off");

    // Scenario B: only barriers, serial skipped.
    ev_barrier = 8'hFF; ev_retire = 8'hFF; step("R4 all at barrier");
    step("R6 commit");
    commit_ack = 1'b1; step("R7 serial skipped");
    step("R7 parallel resumed");

    // Scenario C: priority and ignored events on parked wavefronts.
    ev_atomic[0] = 1'b1; ev_barrier[0] = 1'b1; ev_retire[0] = 1'b1;
    ev_done[1] = 1'b1; ev_atomic[1] = 1'b1;
    ev_barrier[2] = 1'b1; ev_retire[2] = 1'b1;
    step("R12 priority");
    ev_done[0] = 1'b1; ev_done[2] = 1'b1; step("R10 done on parked ignored");
    ev_barrier[3] = 1'b1; ev_barrier[7:5] = 3'b111; step("R4 rest at barrier");
    step("R6 commit");
    commit_ack = 1'b1; step("R7 serial needed by wf0");
    step("R8 wf0 runs alone");
    serial_ack = 1'b1; step("R8 unit 1");
    serial_ack = 1'b1; step("R9 resume");
    step("R10 parked-done had no effect");

    // Random traffic with a different budget.
    quantum_size = 16'd6;
    for (int c = 0; c < 4000; c++) begin
      for (int w = 0; w < NW; w++) begin
        ev_retire[w]  = ($urandom % 2) == 0;
        ev_atomic[w]  = ($urandom % 64) == 0;
        ev_fence[w]   = ($urandom % 64) == 0;
        ev_barrier[w] = ($urandom % 32) == 0;
        ev_done[w]    = ($urandom % 1500) == 0;
      end
      commit_ack = ($urandom % 3) == 0;
      serial_ack = ($urandom % 3) == 0;
      case (m_mode)
        0: step("R2 random parallel");
        1: step("R6 random commit");
        2: step("R8 random serial");
        default: step("R11 random idle");
      endcase
    end

    // Drain to completion.
    for (int c = 0; c < 100 && m_mode != 3; c++) begin
      ev_done = '1; commit_ack = 1'b1; serial_ack = 1'b1;
      step("R11 draining");
    end
    for (int c = 0; c < 5; c++) begin
      ev_retire = '1; ev_atomic = '1; commit_ack = 1'b1; serial_ack = 1'b1;
      step("R11 idle holds");
    end
    vectors++;
    if (kernel_done !== 1'b1 || run_en !== '0) begin
      fails++;
      $display("FAIL R11 final: kdone=%b run_en=%b, expected kdone=1 run_en=0", kernel_done, run_en);
    end
    finish_run();
  end

endmodule